// File: doc/BRIEF.md
# Oversampled Header-Locked Serial Word Receiver

This block takes one serial data line that arrives without any accompanying clock and with a propagation delay that is not known in advance. The line is sampled three times per bit period from a single fast clock, so each sample belongs to one of three phases spaced a third of a bit apart. One shift register is kept per phase. A burst is 19 bits long: a 3-bit header of 0, 1, 0 followed by a 16-bit word, most significant bit first.

A `frame_start` pulse marks the first sample of each burst. After the 57th sample the block checks which phases saw the header in the first three bit slots and picks one of them using a fixed rule that prefers the centre of the valid window. It then presents the word captured on that phase, together with the phase index and a one-cycle strobe. A phase that has been chosen on enough consecutive bursts becomes locked. A locked phase is kept as long as it still sees the header. When it stops seeing the header, the block moves to a new phase and has to lock again. One instance serves one serial source. Several instances can run from the same burst timing, and each one settles on its own phase.

The controller has three states. `S_IDLE` waits for `frame_start`. `S_CAPTURE` takes one sample per cycle. `S_JUDGE` lasts one cycle and evaluates the burst. The transitions are:
- IDLE→CAPTURE on `frame_start`.
- CAPTURE→CAPTURE on every sample. A `frame_start` here restarts the burst.
- CAPTURE→JUDGE after the last sample.
- JUDGE→IDLE when no new burst begins.
- JUDGE→CAPTURE when `frame_start` arrives in the judging cycle.

Top module: `hdr_phase_align`

## Requirements
- R1: While reset is held and afterwards until the first burst is judged, `valid_o`, `sync_err_o` and `locked_o` are 0, `phase_o` is 1 and `word_o` is 0.
- R2: The sample present in the cycle `frame_start` is high is sample 0. Sample i belongs to phase i mod 3 and to bit slot i div 3, for samples 0 to 56. The result of the burst (`valid_o` or `sync_err_o`) is visible in the second cycle after sample 56 is taken.
- R3: A phase qualifies only when its slots 0, 1 and 2 hold 0, 1 and 0.
- R4: The chosen phase depends on the qualifying set, written as bit p set when phase p qualifies:
  - 111→1, 011→1, 110→2, 101→0
  - 001→0, 010→1, 100→2
- R5: On `valid_o`, `word_o` holds slots 3 to 18 of the phase in use, with slot 3 in bit 15, and `phase_o` names that phase.
- R6: When no phase qualifies, `sync_err_o` pulses instead of `valid_o`. In that case `phase_o` and `word_o` keep their values, `locked_o` is 0 and the run of matching choices restarts from zero.
- R7: `locked_o` becomes 1 on the result of the LOCK_FRAMES-th consecutive burst (default 4) that ends in the same phase.
- R8: While locked, the locked phase is kept, and the block stays locked, as long as that phase still qualifies, even when the R4 rule would pick another phase.
- R9: While locked, if the locked phase fails but another phase qualifies, the block switches to the R4 choice, `locked_o` drops to 0, and the new phase counts as the first burst of a new run.
- R10: A `frame_start` in the middle of a burst drops that burst without any result and restarts capture at sample 0.
- R11: `valid_o` and `sync_err_o` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock at three times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | High in the cycle of sample 0 of a burst |
| sdata | input | 1 | Serial data line, already synchronised to `clk` |
| word_o | output | 16 | Recovered word |
| phase_o | output | 2 | Phase the word was taken from |
| valid_o | output | 1 | One-cycle strobe for a new word |
| locked_o | output | 1 | The phase in use is locked |
| sync_err_o | output | 1 | One-cycle strobe when no phase saw the header |

## Verification
Two things can fall in the same cycle: the judging of a finished burst and the capture of sample 0 of the next burst. This happens when `frame_start` arrives in the cycle right after sample 56. The bench provokes it by sending two bursts back to back with no idle gap. The scoreboard then has to receive the first burst's word unchanged, which shows that judging read the shift registers before the new sample entered. It also has to receive the second burst's word on its own strobe 57 cycles later. A burst that is aborted mid-way and then restarted is checked the same way: no strobe may appear for the dropped part.

// File: rtl/hdr_align_pkg.sv
package hdr_align_pkg;

    localparam int PHASES = 3;
    localparam int HDR_W  = 3;
    localparam logic [HDR_W-1:0] HDR_PATTERN = 3'b010;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CAPTURE,
        S_JUDGE
    } align_state_t;

    // Centre of the qualifying run; for a pair, the later phase (2 then 0 wraps).
    function automatic logic [1:0] pick_phase(input logic [PHASES-1:0] q);
        logic [1:0] r;
        unique case (q)
            3'b001:  r = 2'd0;
            3'b010:  r = 2'd1;
            3'b100:  r = 2'd2;
            3'b011:  r = 2'd1;
            3'b110:  r = 2'd2;
            3'b101:  r = 2'd0;
            3'b111:  r = 2'd1;
            default: r = 2'd1;
        endcase
        return r;
    endfunction

    function automatic logic bit_at(input logic [PHASES-1:0] v, input logic [1:0] i);
        logic r;
        unique case (i)
            2'd0:    r = v[0];
            2'd1:    r = v[1];
            default: r = v[2];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hdr_phase_shift.sv
module hdr_phase_shift
    import hdr_align_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [1:0]        cap_ph,
    input  logic              sdata,
    output logic              qual_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int FRAME_W = HDR_W + DATA_W;

    logic [FRAME_W-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (cap_en && (cap_ph == 2'(PH_IDX))) begin
            bits_q <= {bits_q[FRAME_W-2:0], sdata};
        end
    end

    assign qual_o = (bits_q[FRAME_W-1 -: HDR_W] == HDR_PATTERN);
    assign word_o = bits_q[DATA_W-1:0];

endmodule

// File: rtl/hdr_phase_pick.sv
module hdr_phase_pick
    import hdr_align_pkg::*;
(
    input  logic [PHASES-1:0] qual_i,
    output logic [1:0]        best_o,
    output logic              any_o
);
    assign any_o  = |qual_i;
    assign best_o = pick_phase(qual_i);

    // R4
    always_comb begin
        if (any_o) begin
            pick_qualifies_chk: assert (bit_at(qual_i, best_o))
                else $error("chosen phase does not qualify");
        end
    end

endmodule

// File: rtl/hdr_lock_track.sv
module hdr_lock_track
    import hdr_align_pkg::*;
#(
    parameter int LOCK_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [PHASES-1:0] qual_i,
    input  logic [1:0]        best_i,
    input  logic              any_i,
    output logic [1:0]        sel_next_o,
    output logic              locked_next_o
);
    localparam int LOCK_W = $clog2(LOCK_FRAMES + 1);
    localparam logic [LOCK_W-1:0] RUN_MAX = LOCK_W'(LOCK_FRAMES);

    logic [1:0]        sel_q, sel_n;
    logic [LOCK_W-1:0] run_q, run_n;
    logic              locked_now;

    assign locked_now = (run_q == RUN_MAX);

    always_comb begin
        sel_n = sel_q;
        run_n = run_q;
        if (!any_i) begin
            run_n = '0;
        end else if (locked_now && bit_at(qual_i, sel_q)) begin
            run_n = run_q;
        end else if (best_i == sel_q) begin
            run_n = locked_now ? run_q : run_q + LOCK_W'(1);
        end else begin
            sel_n = best_i;
            run_n = LOCK_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 2'd1;
            run_q <= '0;
        end else if (eval_i) begin
            sel_q <= sel_n;
            run_q <= run_n;
        end
    end

    assign sel_next_o    = sel_n;
    assign locked_next_o = (run_n == RUN_MAX);

    // R6
    run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !any_i) |=> (run_q == '0))
        else $error("run not cleared after sync error");

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && locked_now && bit_at(qual_i, sel_q)) |=> (sel_q == $past(sel_q) && locked_now))
        else $error("locked phase dropped while still qualifying");

endmodule

// File: rtl/hdr_phase_align.sv
module hdr_phase_align
    import hdr_align_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int LOCK_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              sdata,
    output logic [DATA_W-1:0] word_o,
    output logic [1:0]        phase_o,
    output logic              valid_o,
    output logic              locked_o,
    output logic              sync_err_o
);
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int SLOT_W  = $clog2(FRAME_W);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);
    localparam logic [1:0]        LAST_PH   = 2'(PHASES - 1);

    align_state_t      state_q, state_n;
    logic [1:0]        ph_q, ph_n;
    logic [SLOT_W-1:0] slot_q, slot_n;
    logic              cap_en;
    logic [1:0]        cap_ph;
    logic              eval;
    logic              last_sample;

    logic [PHASES-1:0] qual;
    logic [DATA_W-1:0] word_arr [PHASES];
    logic [1:0]        best;
    logic              any_ok;
    logic [1:0]        sel_next;
    logic              locked_next;
    logic [DATA_W-1:0] word_sel;

    assign last_sample = (slot_q == LAST_SLOT) && (ph_q == LAST_PH);
    assign eval        = (state_q == S_JUDGE);

    // next state and sample counters
    always_comb begin
        state_n = state_q;
        ph_n    = ph_q;
        slot_n  = slot_q;
        cap_en  = 1'b0;
        cap_ph  = ph_q;
        unique case (state_q)
            S_IDLE, S_JUDGE: begin
                if (frame_start) begin
                    cap_en  = 1'b1;
                    cap_ph  = 2'd0;
                    ph_n    = 2'd1;
                    slot_n  = '0;
                    state_n = S_CAPTURE;
                end else begin
                    state_n = S_IDLE;
                end
            end
            S_CAPTURE: begin
                cap_en = 1'b1;
                if (frame_start) begin
                    cap_ph = 2'd0;
                    ph_n   = 2'd1;
                    slot_n = '0;
                end else if (last_sample) begin
                    state_n = S_JUDGE;
                end else if (ph_q == LAST_PH) begin
                    ph_n   = 2'd0;
                    slot_n = slot_q + SLOT_W'(1);
                end else begin
                    ph_n = ph_q + 2'd1;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ph_q    <= 2'd0;
            slot_q  <= '0;
        end else begin
            state_q <= state_n;
            ph_q    <= ph_n;
            slot_q  <= slot_n;
        end
    end

    for (genvar g = 0; g < PHASES; g++) begin : g_phase
        hdr_phase_shift #(
            .DATA_W (DATA_W),
            .PH_IDX (g)
        ) u_shift (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_en (cap_en),
            .cap_ph (cap_ph),
            .sdata  (sdata),
            .qual_o (qual[g]),
            .word_o (word_arr[g])
        );
    end

    hdr_phase_pick u_pick (
        .qual_i (qual),
        .best_o (best),
        .any_o  (any_ok)
    );

    hdr_lock_track #(
        .LOCK_FRAMES (LOCK_FRAMES)
    ) u_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .eval_i        (eval),
        .qual_i        (qual),
        .best_i        (best),
        .any_i         (any_ok),
        .sel_next_o    (sel_next),
        .locked_next_o (locked_next)
    );

    always_comb begin
        unique case (sel_next)
            2'd0:    word_sel = word_arr[0];
            2'd1:    word_sel = word_arr[1];
            default: word_sel = word_arr[2];
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o     <= '0;
            phase_o    <= 2'd1;
            valid_o    <= 1'b0;
            locked_o   <= 1'b0;
            sync_err_o <= 1'b0;
        end else begin
            valid_o    <= 1'b0;
            sync_err_o <= 1'b0;
            if (eval) begin
                if (any_ok) begin
                    valid_o  <= 1'b1;
                    word_o   <= word_sel;
                    phase_o  <= sel_next;
                    locked_o <= locked_next;
                end else begin
                    sync_err_o <= 1'b1;
                    locked_o   <= 1'b0;
                end
            end
        end
    end

    // R11
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && sync_err_o))
        else $error("valid and sync error together");

    // R11
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || sync_err_o) |=> !(valid_o || sync_err_o))
        else $error("result strobe longer than one cycle");

    // R2
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || sync_err_o) |-> ($past(state_q) == S_JUDGE))
        else $error("result without a judging cycle");

    // R6
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |-> (phase_o == $past(phase_o) && word_o == $past(word_o) && !locked_o))
        else $error("sync error altered outputs");

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CAPTURE && frame_start) |=> (ph_q == 2'd1 && slot_q == '0))
        else $error("mid-burst frame_start did not restart capture");

endmodule

// File: tb/hdr_phase_align_bench.sv
module hdr_phase_align_bench;

    localparam int LOCKN = 4;

    typedef struct {
        bit          err;
        logic [15:0] word;
        logic [1:0]  ph;
        bit          lk;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        sdata = 1'b1;
    logic [15:0] word_o;
    logic [1:0]  phase_o;
    logic        valid_o, locked_o, sync_err_o;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    exp_t exp_q[$];

    logic [1:0]  m_sel = 2'd1;
    int          m_run = 0;
    logic [15:0] m_word = 16'h0;

    always #10 clk = ~clk;

    hdr_phase_align u_hdr_phase_align (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sdata(sdata),
        .word_o(word_o), .phase_o(phase_o), .valid_o(valid_o),
        .locked_o(locked_o), .sync_err_o(sync_err_o)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [1:0] ref_pick(input logic [2:0] q);
        case (q)
            3'b001: return 2'd0;
            3'b010: return 2'd1;
            3'b100: return 2'd2;
            3'b011: return 2'd1;
            3'b110: return 2'd2;
            3'b101: return 2'd0;
            default: return 2'd1;
        endcase
    endfunction

    task automatic drive(input logic fs, input logic v);
        @(negedge clk);
        frame_start = fs;
        sdata = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b1);
    endtask

    // driver: d = line delay in samples, badm = phases whose header 1 is corrupted
    task automatic send_frame(input logic [15:0] dat, input int d, input logic [2:0] badm);
        logic [18:0] fr;
        logic [2:0]  q;
        logic [1:0]  best;
        bit          lk_now;
        exp_t        e;
        fr = {3'b010, dat};
        for (int i = 0; i < 57; i++) begin
            logic v;
            v = (i < d) ? 1'b1 : fr[18 - ((i - d) / 3)];
            if (badm[i % 3] && (i / 3 == 1)) v = ~v;
            drive(i == 0, v);
        end
        for (int p = 0; p < 3; p++) q[p] = (p >= d) && !badm[p];
        best = ref_pick(q);
        lk_now = (m_run == LOCKN);
        if (q == 3'b000) begin
            m_run = 0;
            e = '{1'b1, m_word, m_sel, 1'b0};
        end else begin
            if (lk_now && q[m_sel]) begin
                // R8 locked phase kept
            end else if (best == m_sel) begin
                if (!lk_now) m_run++;
            end else begin
                m_sel = best; m_run = 1;   // R9 relock
            end
            m_word = dat;
            e = '{1'b0, dat, m_sel, (m_run == LOCKN)};
        end
        exp_q.push_back(e);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && (valid_o || sync_err_o)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(sync_err_o == e.err, "R6 err flag", sync_err_o, e.err);
                check(word_o == e.word, "R5 word", word_o, e.word);
                check(phase_o == e.ph, "R4 phase", phase_o, e.ph);
                check(locked_o == e.lk, "R7 lock", locked_o, e.lk);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!valid_o && !sync_err_o && !locked_o, "R1 strobes", {valid_o, sync_err_o, locked_o}, 0);
        check(phase_o == 2'd1 && word_o == 16'h0, "R1 phase/word", {phase_o, word_o}, 32'h10000);
        rst_n = 1'b1;
        idle(3);
        check(!valid_o && !locked_o && phase_o == 2'd1, "R1 after release", {valid_o, locked_o, phase_o}, 1);

        // R2 timing, R3/R4 all phases qualify -> 1, R7 lock after four
        send_frame(16'hA5C3, 0, 3'b000);
        drive(1'b0, 1'b1);
        check(valid_o == 1'b0, "R2 not yet", valid_o, 0);
        drive(1'b0, 1'b1);
        check(valid_o == 1'b1, "R2 result cycle", valid_o, 1);
        drive(1'b0, 1'b1);
        check(valid_o == 1'b0, "R11 one cycle", valid_o, 0);
        idle(2);
        send_frame(16'h0000, 0, 3'b000); idle(3);
        send_frame(16'hFFFF, 0, 3'b000); idle(3);
        send_frame(16'h8001, 0, 3'b000); idle(3);
        check(locked_o == 1'b1, "R7 locked after four", locked_o, 1);

        // R8 delay 1: set 110, table says 2, locked phase 1 kept
        send_frame(16'h1234, 1, 3'b000); idle(3);
        // R9 set 101: locked phase fails -> 0, unlocked
        send_frame(16'h5678, 0, 3'b010); idle(3);
        // R6 no phase qualifies
        send_frame(16'h9ABC, 0, 3'b111); idle(3);
        check(locked_o == 1'b0, "R6 unlocked after error", locked_o, 0);
        // R3 delay 2: only phase 2, lock again (R7)
        for (int k = 0; k < 4; k++) begin
            send_frame(16'h0F0F ^ 16'(k), 2, 3'b000); idle(3);
        end
        // R4 table entries
        send_frame(16'hCAFE, 0, 3'b110); idle(3);   // 001 -> 0
        send_frame(16'hBEEF, 0, 3'b100); idle(3);   // 011 -> 1
        send_frame(16'hDEAD, 0, 3'b001); idle(3);   // 110 -> 2
        send_frame(16'h4242, 0, 3'b101); idle(3);   // 010 -> 1
        // R10 abort mid-burst, restart
        drive(1'b1, 1'b0);
        for (int i = 1; i < 20; i++) drive(1'b0, 1'(i % 2));
        send_frame(16'h7E81, 1, 3'b000); idle(3);
        // R2 back-to-back: next frame_start lands in the judging cycle
        send_frame(16'h3C3C, 0, 3'b000);
        send_frame(16'hC3C3, 0, 3'b000);
        send_frame(16'h0001, 0, 3'b111);
        idle(5);
        check(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule